// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Status Flags

This block is a first-in first-out buffer for 9-bit words. It sits between two unrelated clock domains. The producer writes on its own clock and the consumer reads on another. No ratio or ordering between the two clocks is assumed, and both sides may be active at once. Storage is an on-chip array of `2**AW` words. The default depth is small so that simulation stays short.

Full, half-full and almost-full are computed in the write domain. Empty, output-ready and almost-empty are computed in the read domain. The two almost thresholds are held in a pair of offset registers. After a master reset, both offsets take one of two preset values, chosen by a configuration pin. Software in the write domain can then replace them, either bit by bit over a serial input or a word at a time from the data bus.

A mode pin, sampled during master reset, selects the read behaviour:
- **Request mode:** each word is fetched by a read enable.
- **Fall-through mode:** the head word is presented without being asked for.

Other controls:
- **Rewind:** a rewind pulse replays the buffer from its first location.
- **Partial reset:** empties the buffer but keeps the offsets and the mode.
- **Output enable:** masks the data output.

Top module: `dcf_fifo`

## Requirements
- R1: Words leave in the order they were accepted and unchanged, for any pair of clock rates, including when writes and reads happen at the same time.
- R2: In request mode (mode pin 0 at master reset), `wr_flag` is 1 while 16 words (the default depth) are stored, and a write at that point is dropped. In fall-through mode, `wr_flag` is an input-ready flag: it is 1 while there is room.
- R3: In request mode, `rd_flag` is 1 while nothing is stored. A read enable at that point leaves `dout` and the read pointer unchanged.
- R4: `half_full` is 1 exactly when more than half of the locations hold unread words (more than 8 at the default depth).
- R5: `almost_empty` is 1 when the stored level is at or below the empty offset. `almost_full` is 1 when the write-side level is at or above the depth minus the full offset.
- R6: After master reset, both offsets equal 2 when `cfg_offsel` is 0 and 5 when it is 1.
- R7: While `ld` is 1, each write-clock edge loads `din[AW-1:0]` into an offset instead of storing a word. The first edge loads the empty offset, the next loads the full offset, and they alternate after that.
- R8: While `sen` is 1 and `ld` is 0, each write-clock edge shifts `si` into an 8-bit chain. After 8 edges, the first bit is bit 0 of the empty offset and the last bit is bit 3 of the full offset.
- R9: Partial reset empties the buffer and clears the flags, but keeps both offsets and the read mode.
- R10: In fall-through mode, a word written into an empty buffer appears on `dout` with `rd_flag` (output ready) at 1 within 4 read-clock cycles, without any read enable. A read enable then consumes it.
- R11: In request mode, a read enable with `rd_flag` at 0 places the next word on `dout` at the following read-clock edge.
- R12: A rewind pulse (`rt`) moves the read position back to the first location. In request mode the next read returns the first word written since reset. In fall-through mode `rd_flag` drops on the rewind edge, and the first word is presented one edge later.
- R13: While `oe` is 0, `dout` reads 0 and `dout_drive` is 0. When `oe` returns to 1, the held word is visible again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low: clears data and reloads offsets and mode |
| prst_n | input | 1 | Partial reset, active low: clears data, keeps offsets and mode |
| cfg_fwft | input | 1 | Read mode sampled at master reset (1 = fall-through) |
| cfg_offsel | input | 1 | Selects the preset offsets at master reset |
| wr_en | input | 1 | Write request |
| din | input | 9 | Write data; its low bits are the offset value during parallel load |
| ld | input | 1 | Parallel offset load |
| sen | input | 1 | Serial offset shift enable |
| si | input | 1 | Serial offset data |
| rd_en | input | 1 | Read request |
| rt | input | 1 | Rewind request (read domain) |
| oe | input | 1 | Output enable |
| dout | output | 9 | Read data, masked by `oe` |
| dout_drive | output | 1 | Output driven indication |
| rd_flag | output | 1 | Empty (request mode) or output ready (fall-through mode) |
| wr_flag | output | 1 | Full (request mode) or input ready (fall-through mode) |
| half_full | output | 1 | More than half the locations occupied |
| almost_empty | output | 1 | Level at or below the empty offset |
| almost_full | output | 1 | Level at or above depth minus the full offset |

## Verification
The assertions rely on three things about the inputs:
- The two resets are released away from the clock edges.
- A rewind is only requested while no more than one depth of words has been written since the last reset.
- The offsets are changed only while the read side is idle, because the read domain uses them without a synchroniser.

The stimulus respects all three:
- Resets are released on the opposite clock phase.
- Rewinds are used only in the directed sequences, after at most five writes.
- Offsets are loaded just before a partial reset, and the bench waits several read cycles before looking at `almost_empty`.

The randomised traffic never drives `ld`, `sen` or `rt`.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] from_gray(input logic [31:0] g);
    logic [31:0] b;
    b = g;
    b = b ^ (b >> 1);
    b = b ^ (b >> 2);
    b = b ^ (b >> 4);
    b = b ^ (b >> 8);
    b = b ^ (b >> 16);
    return b;
  endfunction

  function automatic logic ae_hit(input logic [31:0] level, input logic [31:0] off);
    return level <= off;
  endfunction

  function automatic logic af_hit(input logic [31:0] level, input logic [31:0] depth,
                                  input logic [31:0] off);
    return level >= depth - off;
  endfunction

  function automatic logic hf_hit(input logic [31:0] level, input logic [31:0] depth);
    return level > (depth >> 1);
  endfunction
endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
module dcf_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/dcf_offsets.sv
`timescale 1ns/1ps
module dcf_offsets #(
  parameter int AW    = 4,
  parameter int OFS_A = 2,
  parameter int OFS_B = 5
) (
  input  logic          wclk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          offsel,
  input  logic          ld,
  input  logic          sen,
  input  logic          si,
  input  logic [AW-1:0] ld_val,
  output logic [AW-1:0] pae,
  output logic [AW-1:0] paf
);
  localparam int CW = 2 * AW;

  logic [CW-1:0] chain;
  logic          ld_to_full;
  logic          tog_rst_n;

  assign tog_rst_n = mrst_n & prst_n;

  always_ff @(posedge wclk or negedge mrst_n) begin
    if (!mrst_n) begin
      chain <= offsel ? {AW'(OFS_B), AW'(OFS_B)} : {AW'(OFS_A), AW'(OFS_A)};
    end else if (ld) begin
      if (ld_to_full) chain[CW-1:AW] <= ld_val;
      else            chain[AW-1:0]  <= ld_val;
    end else if (sen) begin
      chain <= {si, chain[CW-1:1]};
    end
  end

  always_ff @(posedge wclk or negedge tog_rst_n) begin
    if (!tog_rst_n)  ld_to_full <= 1'b0;
    else if (ld)     ld_to_full <= ~ld_to_full;
  end

  assign pae = chain[AW-1:0];
  assign paf = chain[CW-1:AW];
endmodule

// File: rtl/dcf_wr_ctl.sv
`timescale 1ns/1ps
module dcf_wr_ctl #(
  parameter int AW = 4
) (
  input  logic        wclk,
  input  logic        rst_n,
  input  logic        wr_req,
  input  logic [AW:0] rgray_s,
  output logic [AW:0] wptr,
  output logic [AW:0] wgray,
  output logic [AW:0] wcount,
  output logic        wfull,
  output logic        wr_go
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] rbin_s;
  logic [PW-1:0] wptr_nxt;

  assign rbin_s   = PW'(dcf_pkg::from_gray(32'(rgray_s)));
  assign wcount   = wptr - rbin_s;
  assign wfull    = (wcount == PW'(DEPTH));
  assign wr_go    = wr_req & ~wfull;
  assign wptr_nxt = wptr + PW'(1);

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      wgray <= '0;
    end else if (wr_go) begin
      wptr  <= wptr_nxt;
      wgray <= PW'(dcf_pkg::to_gray(32'(wptr_nxt)));
    end
  end
endmodule

// File: rtl/dcf_rd_ctl.sv
`timescale 1ns/1ps
module dcf_rd_ctl #(
  parameter int AW = 4,
  parameter int DW = 9
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          fwft,
  input  logic          rd_en,
  input  logic          rt,
  input  logic [AW:0]   wgray_s,
  input  logic [DW-1:0] mem_q,
  output logic [AW:0]   rptr,
  output logic [AW:0]   rgray,
  output logic [AW:0]   rcount,
  output logic          rempty,
  output logic          or_q,
  output logic [DW-1:0] dq,
  output logic          fetch
);
  localparam int PW = AW + 1;

  logic [PW-1:0] wbin_s;
  logic [PW-1:0] rptr_nxt;

  assign wbin_s = PW'(dcf_pkg::from_gray(32'(wgray_s)));
  assign rcount = wbin_s - rptr;
  assign rempty = (rcount == '0);
  assign fetch  = ~rt & ~rempty & (fwft ? (~or_q | rd_en) : rd_en);

  always_comb begin
    if (rt)         rptr_nxt = '0;
    else if (fetch) rptr_nxt = rptr + PW'(1);
    else            rptr_nxt = rptr;
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rptr  <= '0;
      rgray <= '0;
      or_q  <= 1'b0;
      dq    <= '0;
    end else begin
      rptr  <= rptr_nxt;
      rgray <= PW'(dcf_pkg::to_gray(32'(rptr_nxt)));
      if (rt)                or_q <= 1'b0;
      else if (fetch)        or_q <= 1'b1;
      else if (fwft & rd_en) or_q <= 1'b0;
      if (fetch) dq <= mem_q;
    end
  end
endmodule

// File: rtl/dcf_fifo.sv
`timescale 1ns/1ps
module dcf_fifo #(
  parameter int AW    = 4,
  parameter int DW    = 9,
  parameter int OFS_A = 2,
  parameter int OFS_B = 5
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          cfg_fwft,
  input  logic          cfg_offsel,
  input  logic          wr_en,
  input  logic [DW-1:0] din,
  input  logic          ld,
  input  logic          sen,
  input  logic          si,
  input  logic          rd_en,
  input  logic          rt,
  input  logic          oe,
  output logic [DW-1:0] dout,
  output logic          dout_drive,
  output logic          rd_flag,
  output logic          wr_flag,
  output logic          half_full,
  output logic          almost_empty,
  output logic          almost_full
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic          ptr_rst_n;
  logic          fwft_q;
  logic [PW-1:0] wptr, wgray, wcount, wgray_s;
  logic [PW-1:0] rptr, rgray, rcount, rgray_s;
  logic          wfull, wr_go, wr_req;
  logic          rempty, or_q, fetch;
  logic [DW-1:0] dq, mem_q;
  logic [AW-1:0] pae, paf;
  logic [DW-1:0] mem [DEPTH];

  assign ptr_rst_n = mrst_n & prst_n;
  assign wr_req    = wr_en & ~ld & ~sen;

  always_ff @(posedge rclk or negedge mrst_n) begin
    if (!mrst_n) fwft_q <= cfg_fwft;
    else         fwft_q <= fwft_q;
  end

  dcf_offsets #(.AW(AW), .OFS_A(OFS_A), .OFS_B(OFS_B)) u_ofs (
    .wclk(wclk), .mrst_n(mrst_n), .prst_n(prst_n), .offsel(cfg_offsel),
    .ld(ld), .sen(sen), .si(si), .ld_val(din[AW-1:0]), .pae(pae), .paf(paf));

  dcf_sync #(.W(PW)) u_rsync (.clk(wclk), .rst_n(ptr_rst_n), .d(rgray), .q(rgray_s));
  dcf_sync #(.W(PW)) u_wsync (.clk(rclk), .rst_n(ptr_rst_n), .d(wgray), .q(wgray_s));

  dcf_wr_ctl #(.AW(AW)) u_wr (
    .wclk(wclk), .rst_n(ptr_rst_n), .wr_req(wr_req), .rgray_s(rgray_s),
    .wptr(wptr), .wgray(wgray), .wcount(wcount), .wfull(wfull), .wr_go(wr_go));

  dcf_rd_ctl #(.AW(AW), .DW(DW)) u_rd (
    .rclk(rclk), .rst_n(ptr_rst_n), .fwft(fwft_q), .rd_en(rd_en), .rt(rt),
    .wgray_s(wgray_s), .mem_q(mem_q), .rptr(rptr), .rgray(rgray), .rcount(rcount),
    .rempty(rempty), .or_q(or_q), .dq(dq), .fetch(fetch));

  always_ff @(posedge wclk) begin
    if (wr_go) mem[wptr[AW-1:0]] <= din;
  end
  assign mem_q = mem[rptr[AW-1:0]];

  assign rd_flag      = fwft_q ? or_q : rempty;
  assign wr_flag      = fwft_q ? ~wfull : wfull;
  assign half_full    = dcf_pkg::hf_hit(32'(wcount), 32'(DEPTH));
  assign almost_full  = dcf_pkg::af_hit(32'(wcount), 32'(DEPTH), 32'(paf));
  assign almost_empty = dcf_pkg::ae_hit(32'(rcount) + 32'(fwft_q & or_q), 32'(pae));
  assign dout         = oe ? dq : '0;
  assign dout_drive   = oe;
endmodule

// File: rtl/dcf_fifo_chk.sv
`timescale 1ns/1ps
module dcf_fifo_chk #(
  parameter int AW = 4
) (
  input logic        wclk,
  input logic        rclk,
  input logic        rst_n,
  input logic        wfull,
  input logic [AW:0] wptr,
  input logic [AW:0] wgray,
  input logic [AW:0] wcount,
  input logic        half_full,
  input logic        rempty,
  input logic [AW:0] rptr,
  input logic        rt
);
  localparam int DEPTH = 1 << AW;

  p_no_overflow_r2: assert property (@(posedge wclk) disable iff (!rst_n)
    wfull |=> $stable(wptr));

  p_level_bound_r2: assert property (@(posedge wclk) disable iff (!rst_n)
    32'(wcount) <= DEPTH);

  p_no_underflow_r3: assert property (@(posedge rclk) disable iff (!rst_n)
    (rempty && !rt) |=> $stable(rptr));

  p_gray_step_r1: assert property (@(posedge wclk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);

  p_full_is_half_r4: assert property (@(posedge wclk) disable iff (!rst_n)
    wfull |-> half_full);

  p_rewind_r12: assert property (@(posedge rclk) disable iff (!rst_n)
    rt |=> (rptr == '0));
endmodule

bind dcf_fifo dcf_fifo_chk #(.AW(AW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(ptr_rst_n), .wfull(wfull), .wptr(wptr),
  .wgray(wgray), .wcount(wcount), .half_full(half_full), .rempty(rempty),
  .rptr(rptr), .rt(rt));

// File: tb/test_dcf_fifo.sv
`timescale 1ns/1ps
module test_dcf_fifo;
  logic       wclk = 1'b0, rclk = 1'b0;
  logic       mrst_n = 1'b0, prst_n = 1'b1, cfg_fwft = 1'b0, cfg_offsel = 1'b0;
  logic       wr_en = 1'b0, ld = 1'b0, sen = 1'b0, si = 1'b0;
  logic       rd_en = 1'b0, rt = 1'b0, oe = 1'b1;
  logic [8:0] din = '0;
  logic [8:0] dout;
  logic       dout_drive, rd_flag, wr_flag, half_full, almost_empty, almost_full;

  int checks = 0, failures = 0;
  realtime rhalf = 10.0;
  logic [8:0] q[$];
  bit wdone;
  bit fwft_mode;

  dcf_fifo i_dcf_fifo (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n), .cfg_fwft(cfg_fwft),
    .cfg_offsel(cfg_offsel), .wr_en(wr_en), .din(din), .ld(ld), .sen(sen), .si(si),
    .rd_en(rd_en), .rt(rt), .oe(oe), .dout(dout), .dout_drive(dout_drive),
    .rd_flag(rd_flag), .wr_flag(wr_flag), .half_full(half_full),
    .almost_empty(almost_empty), .almost_full(almost_full));

  always #10 wclk = ~wclk;
  initial begin
    #3.1;
    forever #(rhalf) rclk = ~rclk;
  end

  function automatic logic [8:0] pat(input int i);
    return 9'((i * 37 + 5) % 512);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_mrst(input bit fw, input bit sel);
    cfg_fwft = fw; cfg_offsel = sel; fwft_mode = fw;
    mrst_n = 1'b0;
    repeat (3) @(negedge wclk);
    repeat (3) @(negedge rclk);
    @(negedge wclk) mrst_n = 1'b1;
    repeat (2) @(negedge rclk);
  endtask

  task automatic do_prst();
    prst_n = 1'b0;
    repeat (2) @(negedge wclk);
    repeat (2) @(negedge rclk);
    @(negedge wclk) prst_n = 1'b1;
    repeat (2) @(negedge rclk);
  endtask

  task automatic wr_n(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk) begin wr_en = 1'b1; din = pat(base + i); end
    end
    @(negedge wclk) wr_en = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(negedge rclk);
  endtask

  task automatic rd1(output logic [8:0] v);
    @(negedge rclk) rd_en = 1'b1;
    @(negedge rclk) rd_en = 1'b0;
    v = dout;
  endtask

  task automatic writer(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      wr_en = ($urandom % 4) != 0;
      din = 9'($urandom);
      if (wr_en && (fwft_mode ? wr_flag : !wr_flag)) q.push_back(din);
    end
    @(negedge wclk) wr_en = 1'b0;
    wdone = 1'b1;
  endtask

  task automatic reader();
    logic [8:0] exp_v = '0;
    bit pend = 1'b0;
    int iter = 0;
    while ((!wdone || q.size() > 0) && iter < 6000) begin
      @(negedge rclk);
      iter++;
      if (fwft_mode) begin
        rd_en = ($urandom % 4) != 0;
        if (rd_flag) begin
          chk("R1 fall-through order", int'(dout), int'(q[0]));
          if (rd_en && q.size() > 0) void'(q.pop_front());
        end
      end else begin
        if (pend) begin
          chk("R1/R11 request order", int'(dout), int'(exp_v));
          pend = 1'b0;
        end
        rd_en = ($urandom % 4) != 0;
        if (rd_en && !rd_flag && q.size() > 0) begin
          exp_v = q.pop_front();
          pend = 1'b1;
        end
      end
    end
    @(negedge rclk);
    rd_en = 1'b0;
    if (pend) chk("R1/R11 request order", int'(dout), int'(exp_v));
  endtask

  initial begin
    #3500000;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [8:0] v;
    int k;
    void'($urandom(32'd20240611));

    // reset state, request mode, preset A
    do_mrst(1'b0, 1'b0);
    chk("R3 empty after reset", int'(rd_flag), 1);
    chk("R2 not full after reset", int'(wr_flag), 0);
    chk("R4 half low after reset", int'(half_full), 0);
    chk("R5 almost_empty after reset", int'(almost_empty), 1);
    chk("R5 almost_full after reset", int'(almost_full), 0);

    // default offsets 2/2, fill to full
    wr_n(2, 0); settle();
    chk("R6 ae at level 2 off 2", int'(almost_empty), 1);
    wr_n(1, 2); settle();
    chk("R6 ae at level 3 off 2", int'(almost_empty), 0);
    wr_n(5, 3);
    chk("R4 half at 8", int'(half_full), 0);
    wr_n(1, 8);
    chk("R4 half at 9", int'(half_full), 1);
    wr_n(4, 9);
    chk("R5 af at 13 off 2", int'(almost_full), 0);
    wr_n(1, 13);
    chk("R5 af at 14 off 2", int'(almost_full), 1);
    wr_n(2, 14);
    chk("R2 full at 16", int'(wr_flag), 1);
    wr_n(2, 400);
    settle();
    for (int i = 0; i < 16; i++) begin
      rd1(v);
      chk("R11 read data", int'(v), int'(pat(i)));
    end
    settle();
    chk("R2 writes while full dropped, empty now (R3)", int'(rd_flag), 1);
    rd1(v);
    chk("R3 read while empty leaves dout", int'(v), int'(pat(15)));

    // preset B 5/5
    do_mrst(1'b0, 1'b1);
    wr_n(5, 20); settle();
    chk("R6 ae at 5 off 5", int'(almost_empty), 1);
    wr_n(1, 25); settle();
    chk("R6 ae at 6 off 5", int'(almost_empty), 0);
    wr_n(4, 26);
    chk("R6 af at 10 off 5", int'(almost_full), 0);
    wr_n(1, 30);
    chk("R6 af at 11 off 5", int'(almost_full), 1);

    // parallel load 3/6 then partial reset
    @(negedge wclk) begin ld = 1'b1; din = 9'd3; end
    @(negedge wclk) din = 9'd6;
    @(negedge wclk) ld = 1'b0;
    do_prst();
    chk("R9 empty after partial reset", int'(rd_flag), 1);
    chk("R9 not full after partial reset", int'(wr_flag), 0);
    chk("R9 half cleared", int'(half_full), 0);
    wr_n(3, 40); settle();
    chk("R7 ae at 3 off 3", int'(almost_empty), 1);
    wr_n(1, 43); settle();
    chk("R7 ae at 4 off 3", int'(almost_empty), 0);
    wr_n(5, 44);
    chk("R7 af at 9 off 6", int'(almost_full), 0);
    wr_n(1, 49);
    chk("R7 af at 10 off 6", int'(almost_full), 1);

    // serial load: empty offset 1, full offset 7
    for (int b = 0; b < 8; b++) begin
      @(negedge wclk) begin sen = 1'b1; si = (8'h71 >> b) & 8'h01; end
    end
    @(negedge wclk) sen = 1'b0;
    do_prst();
    wr_n(1, 60); settle();
    chk("R8 ae at 1 off 1", int'(almost_empty), 1);
    wr_n(1, 61); settle();
    chk("R8 ae at 2 off 1", int'(almost_empty), 0);
    wr_n(6, 62);
    chk("R8 af at 8 off 7", int'(almost_full), 0);
    wr_n(1, 68);
    chk("R8 af at 9 off 7", int'(almost_full), 1);

    // master reset brings defaults back
    do_mrst(1'b0, 1'b0);
    wr_n(2, 70); settle();
    chk("R6 defaults restored", int'(almost_empty), 1);

    // rewind in request mode
    do_mrst(1'b0, 1'b0);
    wr_n(5, 100); settle();
    for (int i = 0; i < 3; i++) begin
      rd1(v);
      chk("R11 read before rewind", int'(v), int'(pat(100 + i)));
    end
    @(negedge rclk) rt = 1'b1;
    @(negedge rclk) rt = 1'b0;
    rd1(v);
    chk("R12 request-mode replay", int'(v), int'(pat(100)));

    // fall-through mode
    do_mrst(1'b1, 1'b0);
    chk("R2 input ready after reset", int'(wr_flag), 1);
    chk("R10 no output ready when empty", int'(rd_flag), 0);
    wr_n(1, 200);
    k = 0;
    for (int i = 1; i <= 6; i++) begin
      @(negedge rclk);
      if (rd_flag && k == 0) k = i;
    end
    chk("R10 first-word latency in range", int'(k >= 2 && k <= 4), 1);
    chk("R10 head word without read", int'(dout), int'(pat(200)));
    @(negedge rclk) rd_en = 1'b1;
    @(negedge rclk) rd_en = 1'b0;
    chk("R10 read consumes word", int'(rd_flag), 0);
    wr_n(3, 210);
    do_prst();
    chk("R9 mode kept, input ready", int'(wr_flag), 1);
    chk("R9 output ready cleared", int'(rd_flag), 0);
    wr_n(4, 300); settle();
    chk("R9 fall-through kept", int'(rd_flag), 1);
    chk("R10 head after partial reset", int'(dout), int'(pat(300)));
    @(negedge rclk) rd_en = 1'b1;
    @(negedge rclk);
    @(negedge rclk) rd_en = 1'b0;
    chk("R10 two reads advance", int'(dout), int'(pat(302)));
    @(negedge rclk) rt = 1'b1;
    @(negedge rclk) rt = 1'b0;
    chk("R12 ready drops on rewind", int'(rd_flag), 0);
    @(negedge rclk);
    chk("R12 ready one edge later", int'(rd_flag), 1);
    chk("R12 replay first word", int'(dout), int'(pat(300)));

    // output enable mask
    @(negedge rclk) oe = 1'b0;
    #1;
    chk("R13 dout masked", int'(dout), 0);
    chk("R13 drive low", int'(dout_drive), 0);
    @(negedge rclk) oe = 1'b1;
    #1;
    chk("R13 dout restored", int'(dout), int'(pat(300)));

    // randomised traffic with several clock ratios and both modes
    for (int ph = 0; ph < 4; ph++) begin
      case (ph)
        0: rhalf = 7.3;
        1: rhalf = 23.7;
        2: rhalf = 23.7;
        default: rhalf = 7.3;
      endcase
      do_mrst(ph[0], 1'b0);
      q.delete();
      wdone = 1'b0;
      fork
        writer(250);
        reader();
      join
      chk("R1 all words delivered", q.size(), 0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule